// File: doc/BRIEF.md
# Inter-Block Live Value Cache

This block stores values that survive from one basic block of a kernel to later basic blocks, one word per thread for each live value. Producing blocks write a value only for the threads that actually ran them, and consuming blocks read it back by thread and value identifier. It takes the place of a register file for values that cross block boundaries. Values that live inside a single block never come here.

A small pool of slots backs the identifiers. A slot is claimed the first time any thread writes an unmapped identifier. Each thread has its own valid bit in the slot. Once no later block needs an identifier, a release command returns its slot to the pool, and a later identifier can then reuse it. The data words sit in a simple dual-port RAM that can map onto block RAM. The valid bits and the identifier-to-slot table are kept in flops, so a release can clear a whole slot in one cycle. `NUM_THREADS` must be a power of two.

Top module: `lvc_top`

## Requirements
- R1: After reset no identifier is mapped and every valid bit is clear. `rd_ack`, `rd_miss` and `wr_ovf` are low while reset is applied and in the first cycle after it.
- R2: A read issued with `rd_en` in cycle N raises `rd_ack` in cycle N+1 and in no other cycle. A read of a value that this thread wrote returns that data with `rd_miss` low.
- R3: Writes are per thread. Threads that never wrote an identifier read it as a miss, even when other threads wrote it.
- R4: Reads do not consume data. The same value may be read any number of times until its identifier is released.
- R5: A read of an unmapped identifier, or of one that is not valid for the requesting thread, returns `rd_data` = 0 with `rd_miss` high.
- R6: A write to an unmapped identifier while every slot is mapped raises `wr_ovf` in the next cycle and changes nothing. That identifier stays unmapped, and other identifiers keep their data.
- R7: A release of a mapped identifier unmaps it, clears all its valid bits and frees its slot from the next cycle on. A new identifier can then take that slot and inherits no valid bits from it. A release of an unmapped identifier has no effect.
- R8: A write and a read to the same identifier and thread in the same cycle return the state from before the write. This is the old data, or a miss if the entry was not yet valid.
- R9: A write and a release to the same identifier in the same cycle drop the write. The release still takes effect, and no overflow is flagged.
- R10: A second write to the same identifier and thread replaces the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_tid | input | $clog2(NUM_THREADS) | Writing thread |
| wr_lvid | input | $clog2(NUM_IDS) | Identifier being written |
| wr_data | input | DATA_W | Word to store |
| rel_en | input | 1 | Release request |
| rel_lvid | input | $clog2(NUM_IDS) | Identifier to release |
| rd_en | input | 1 | Read request |
| rd_tid | input | $clog2(NUM_THREADS) | Reading thread |
| rd_lvid | input | $clog2(NUM_IDS) | Identifier being read |
| rd_ack | output | 1 | Read result present (one cycle after rd_en) |
| rd_data | output | DATA_W | Read word, zero on a miss |
| rd_miss | output | 1 | Read found no valid entry |
| wr_ovf | output | 1 | Previous cycle's write found no free slot |

## Verification
The assertions assume that reset is held for at least one clock edge before any request. They also assume that the inputs are stable around the rising edge. An overflow is only checked against a full slot pool, because the checker takes the pool occupancy as the sole legal cause of `wr_ovf`. The stimulus changes inputs only on falling edges, holds reset for several cycles first, and issues at most one write, one read and one release per cycle. It fills the pool exactly to its slot count before it provokes an overflow.

// File: rtl/lvc_pkg.sv
package lvc_pkg;
  localparam int LVC_THREADS = 8;
  localparam int LVC_IDS     = 16;
  localparam int LVC_SLOTS   = 8;
  localparam int LVC_DATA_W  = 32;
endpackage

// File: rtl/lvc_map.sv
module lvc_map #(
  parameter int NUM_IDS   = 16,
  parameter int NUM_SLOTS = 8,
  localparam int ID_W     = $clog2(NUM_IDS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ID_W-1:0]      wr_id,
  input  logic                 rel_en,
  input  logic [ID_W-1:0]      rel_id,
  input  logic [ID_W-1:0]      rd_id,
  output logic                 wr_go,
  output logic [SLOT_W-1:0]    wr_slot,
  output logic                 ovf_now,
  output logic                 rel_go,
  output logic [SLOT_W-1:0]    rel_slot,
  output logic                 rd_mapped,
  output logic [SLOT_W-1:0]    rd_slot,
  output logic [NUM_SLOTS-1:0] slot_used
);
  logic [NUM_IDS-1:0] id_live;
  logic [SLOT_W-1:0]  id_slot [NUM_IDS];
  logic [SLOT_W-1:0]  free_idx;
  logic               any_free, wr_hit, rel_same, alloc;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int s = NUM_SLOTS-1; s >= 0; s--) begin
      if (!slot_used[s]) begin
        free_idx = SLOT_W'(s);
        any_free = 1'b1;
      end
    end
  end

  assign wr_hit    = id_live[wr_id];
  assign rel_same  = rel_en && (rel_id == wr_id);
  assign wr_go     = wr_en && !rel_same && (wr_hit || any_free);
  assign ovf_now   = wr_en && !rel_same && !wr_hit && !any_free;
  assign alloc     = wr_go && !wr_hit;
  assign wr_slot   = wr_hit ? id_slot[wr_id] : free_idx;
  assign rel_go    = rel_en && id_live[rel_id];
  assign rel_slot  = id_slot[rel_id];
  assign rd_mapped = id_live[rd_id];
  assign rd_slot   = id_slot[rd_id];

  always_ff @(posedge clk) begin
    if (rst) begin
      id_live   <= '0;
      slot_used <= '0;
      for (int i = 0; i < NUM_IDS; i++) id_slot[i] <= '0;
    end else begin
      if (alloc) begin
        id_live[wr_id]      <= 1'b1;
        id_slot[wr_id]      <= free_idx;
        slot_used[free_idx] <= 1'b1;
      end
      if (rel_go) begin
        id_live[rel_id]     <= 1'b0;
        slot_used[rel_slot] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lvc_valid.sv
module lvc_valid #(
  parameter int NUM_SLOTS   = 8,
  parameter int NUM_THREADS = 8,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [TID_W-1:0]  set_tid,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [TID_W-1:0]  rd_tid,
  output logic              rd_valid
);
  logic [NUM_THREADS-1:0] vbits [NUM_SLOTS];

  assign rd_valid = vbits[rd_slot][rd_tid];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) vbits[s] <= '0;
    end else begin
      if (clr_en) vbits[clr_slot] <= '0;
      if (set_en) vbits[set_slot][set_tid] <= 1'b1;
    end
  end
endmodule

// File: rtl/lvc_store.sv
module lvc_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lvc_top.sv
module lvc_top #(
  parameter int NUM_THREADS = lvc_pkg::LVC_THREADS,
  parameter int NUM_IDS     = lvc_pkg::LVC_IDS,
  parameter int NUM_SLOTS   = lvc_pkg::LVC_SLOTS,
  parameter int DATA_W      = lvc_pkg::LVC_DATA_W,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int ID_W       = $clog2(NUM_IDS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int DEPTH      = NUM_SLOTS * NUM_THREADS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [ID_W-1:0]   wr_lvid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rel_en,
  input  logic [ID_W-1:0]   rel_lvid,
  input  logic              rd_en,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [ID_W-1:0]   rd_lvid,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_miss,
  output logic              wr_ovf
);
  logic                 wr_go, ovf_now, rel_go, rd_mapped, rd_valid, hit_q;
  logic [SLOT_W-1:0]    wr_slot, rel_slot, rd_slot;
  logic [NUM_SLOTS-1:0] slot_used_w;
  logic [DATA_W-1:0]    ram_q;

  lvc_map #(.NUM_IDS(NUM_IDS), .NUM_SLOTS(NUM_SLOTS)) u_map (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_id(wr_lvid),
    .rel_en(rel_en), .rel_id(rel_lvid), .rd_id(rd_lvid),
    .wr_go(wr_go), .wr_slot(wr_slot), .ovf_now(ovf_now),
    .rel_go(rel_go), .rel_slot(rel_slot),
    .rd_mapped(rd_mapped), .rd_slot(rd_slot), .slot_used(slot_used_w)
  );

  lvc_valid #(.NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS)) u_valid (
    .clk(clk), .rst(rst),
    .set_en(wr_go), .set_slot(wr_slot), .set_tid(wr_tid),
    .clr_en(rel_go), .clr_slot(rel_slot),
    .rd_slot(rd_slot), .rd_tid(rd_tid), .rd_valid(rd_valid)
  );

  lvc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .we(wr_go), .waddr({wr_slot, wr_tid}), .wdata(wr_data),
    .raddr({rd_slot, rd_tid}), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack <= 1'b0;
      hit_q  <= 1'b0;
      wr_ovf <= 1'b0;
    end else begin
      rd_ack <= rd_en;
      hit_q  <= rd_en && rd_mapped && rd_valid;
      wr_ovf <= ovf_now;
    end
  end

  assign rd_data = hit_q ? ram_q : '0;
  assign rd_miss = rd_ack && !hit_q;
endmodule

// File: rtl/lvc_checker.sv
module lvc_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic                 rd_ack,
  input logic                 rd_miss,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 wr_ovf,
  input logic [NUM_SLOTS-1:0] slot_used
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_ack && !rd_miss && !wr_ovf));
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_ack);
  assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_ack);
  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rd_miss |-> (rd_ack && rd_data == '0));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ovf |-> ($past(wr_en) && $past(&slot_used)));
endmodule

bind lvc_top lvc_checker #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .rd_ack(rd_ack),
  .rd_miss(rd_miss), .rd_data(rd_data), .wr_ovf(wr_ovf), .slot_used(slot_used_w)
);

// File: tb/sim_lvc_top.sv
module sim_lvc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rel_en = 0, rd_en = 0;
  logic [2:0]  wr_tid = 0, rd_tid = 0;
  logic [3:0]  wr_lvid = 0, rel_lvid = 0, rd_lvid = 0;
  logic [31:0] wr_data = 0;
  logic        rd_ack, rd_miss, wr_ovf;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_errs   = 0;

  logic [31:0] exp_rd_d [$];
  logic        exp_rd_m [$];
  string       exp_rd_t [$];
  logic        exp_ov   [$];
  string       exp_ov_t [$];

  always #10 clk = ~clk;

  lvc_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tid(wr_tid), .wr_lvid(wr_lvid),
    .wr_data(wr_data), .rel_en(rel_en), .rel_lvid(rel_lvid), .rd_en(rd_en),
    .rd_tid(rd_tid), .rd_lvid(rd_lvid), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_miss(rd_miss), .wr_ovf(wr_ovf)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expectations are queued for the monitor
  task automatic op(input bit we, input int wt, input int wid, input logic [31:0] wd,
                    input bit re, input int rt, input int rid,
                    input logic [31:0] ed, input bit em,
                    input bit rl, input int rlid, input bit eov, input string tag);
    @(negedge clk);
    wr_en = we; wr_tid = 3'(wt); wr_lvid = 4'(wid); wr_data = wd;
    rd_en = re; rd_tid = 3'(rt); rd_lvid = 4'(rid);
    rel_en = rl; rel_lvid = 4'(rlid);
    exp_ov.push_back(eov); exp_ov_t.push_back(tag);
    if (re) begin
      exp_rd_d.push_back(ed); exp_rd_m.push_back(em); exp_rd_t.push_back(tag);
    end
  endtask

  task automatic wr(input int t, input int id, input logic [31:0] d, input bit eov, input string tag);
    op(1, t, id, d, 0, 0, 0, 0, 0, 0, 0, eov, tag);
  endtask
  task automatic rd(input int t, input int id, input logic [31:0] ed, input bit em, input string tag);
    op(0, 0, 0, 0, 1, t, id, ed, em, 0, 0, 0, tag);
  endtask
  task automatic rel(input int id, input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, id, 0, tag);
  endtask
  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // monitor: outputs registered at a rising edge belong to the op set at the prior falling edge
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      if (exp_ov.size() > 0) begin
        logic e; string tg;
        e = exp_ov.pop_front(); tg = exp_ov_t.pop_front();
        check(wr_ovf === e, tg, "wr_ovf", 32'(wr_ovf), 32'(e));
      end
      if (exp_rd_d.size() > 0) begin
        logic [31:0] d; logic m; string tg;
        d = exp_rd_d.pop_front(); m = exp_rd_m.pop_front(); tg = exp_rd_t.pop_front();
        check(rd_ack === 1'b1, tg, "rd_ack", 32'(rd_ack), 32'd1);
        check(rd_data === d, tg, "rd_data", rd_data, d);
        check(rd_miss === m, tg, "rd_miss", 32'(rd_miss), 32'(m));
      end else begin
        check(rd_ack === 1'b0, "R2", "stray rd_ack", 32'(rd_ack), 32'd0);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_ack === 1'b0, "R1", "rd_ack in reset", 32'(rd_ack), 32'd0);
    check(wr_ovf === 1'b0, "R1", "wr_ovf in reset", 32'(wr_ovf), 32'd0);
    check(rd_miss === 1'b0, "R1", "rd_miss in reset", 32'(rd_miss), 32'd0);
    rst = 1'b0;
    idle();
    rd(0, 3, 32'h0, 1, "R1");
    rd(0, 0, 32'h0, 1, "R5");
    // per-thread writes to id 1 (threads 1 and 3)
    wr(1, 1, 32'h101, 0, "R2");
    wr(3, 1, 32'h103, 0, "R2");
    rd(1, 1, 32'h101, 0, "R2");
    rd(3, 1, 32'h103, 0, "R2");
    rd(2, 1, 32'h0, 1, "R3");
    rd(1, 1, 32'h101, 0, "R4");
    rd(1, 1, 32'h101, 0, "R4");
    // same-cycle write and read
    op(1, 1, 1, 32'hBEEF, 1, 1, 1, 32'h101, 0, 0, 0, 0, "R8");
    rd(1, 1, 32'hBEEF, 0, "R10");
    op(1, 5, 1, 32'h505, 1, 5, 1, 32'h0, 1, 0, 0, 0, "R8");
    rd(5, 1, 32'h505, 0, "R8");
    // release id 1
    rel(1, "R7");
    rd(1, 1, 32'h0, 1, "R7");
    rd(5, 1, 32'h0, 1, "R7");
    // fill all eight slots with ids 2..9
    for (int i = 2; i < 10; i++) wr(0, i, 32'(i * 16), 0, "R6");
    wr(0, 10, 32'hDEAD, 1, "R6");
    rd(0, 10, 32'h0, 1, "R6");
    rd(0, 2, 32'h20, 0, "R6");
    rd(0, 9, 32'h90, 0, "R6");
    // free one slot and reuse it
    rel(5, "R7");
    wr(0, 10, 32'hAA, 0, "R7");
    rd(0, 10, 32'hAA, 0, "R7");
    rd(1, 10, 32'h0, 1, "R7");
    rd(0, 5, 32'h0, 1, "R7");
    // release of an unmapped id has no effect
    rel(15, "R7");
    rd(0, 3, 32'h30, 0, "R7");
    wr(0, 12, 32'h1, 1, "R7");
    // write and release of the same id in one cycle
    op(1, 1, 2, 32'h55, 0, 0, 0, 0, 0, 1, 2, 0, "R9");
    rd(0, 2, 32'h0, 1, "R9");
    rd(1, 2, 32'h0, 1, "R9");
    wr(0, 11, 32'h77, 0, "R9");
    rd(0, 11, 32'h77, 0, "R9");
    idle();
    idle();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule